// File: doc/BRIEF.md
# PC Range Cycle Profiler

This block sits beside a soft processor and watches it without ever holding it back. On every clock it takes the program counter, a qualifier that says the program counter is valid, and two single-bit cache event lines (hit and miss). It holds a small set of programmable address windows. Each window has an inclusive lower and upper bound and its own cycle counter. A window's counter advances on each qualified clock in which the program counter lies inside that window, so the count is the number of cycles spent in that stretch of code, for example one function. Two further counters tally cache hits and cache misses.

Software programs the window bounds, a per-window enable mask and a global run bit through a plain register port with a write strobe. A write to a dedicated address clears every counter. All counters and settings can be read back combinationally. The block has no output towards the processor, so profiling cannot change how the program runs.

Top module: `pc_window_profiler`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every counter, bound, enable bit and the run bit read as zero.
- R2: A window matches when lower <= pc <= upper, with both bounds inclusive. A pc one below the lower bound or one above the upper bound does not match.
- R3: A counter advances by exactly one in each clock in which its condition holds, and otherwise keeps its value.
- R4: A window whose lower bound is greater than its upper bound never matches.
- R5: Windows may overlap. Every matching window advances in the same cycle.
- R6: Window counters advance only while the run bit is 1 and `pc_valid` is high. The hit and miss counters advance only while the run bit is 1.
- R7: A window whose enable bit is 0 does not count.
- R8: Each clock with `cache_hit` high adds one to the hit counter (read address 2). Each clock with `cache_miss` high adds one to the miss counter (read address 3).
- R9: Counters saturate: a counter at its all-ones value stays there instead of wrapping.
- R10: A write to address 1 clears all counters at that clock edge. The clear wins over any increment in the same cycle.
- R11: Register map: address 0 holds run in bit 0 and the enable of window i in bit 1+i. Address 8+2i holds the lower bound of window i. Address 9+2i holds its upper bound. Address 8+2*NWIN+i holds the counter of window i. All of these read back on `rd_data` combinationally. A write takes effect at the clock edge, and counting in that same cycle still uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | AW | Program counter sampled each clock |
| pc_valid | input | 1 | Program counter is valid this cycle |
| cache_hit | input | 1 | Cache hit event |
| cache_miss | input | 1 | Cache miss event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | RAW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | RAW | Register read address |
| rd_data | output | DW | Register read data (combinational) |

## Verification
Directed program counters placed exactly on each bound and one step outside it separate an inclusive compare from an exclusive or off-by-one compare. A pc inside two overlapping windows, and a pc inside an inverted window, show whether windows are evaluated independently and whether reversed bounds are rejected. Stretches with `pc_valid` low, with the run bit off and with one window disabled tell the qualifiers apart. A long dwell in one window drives its narrow counter into saturation. Random program counters, valid bits, cache events and occasional clears, checked cycle by cycle against a bench model, expose wrong gating and a clear that loses to an increment.

// File: rtl/pc_window_profiler.sv
module pc_window_profiler #(
  parameter int NWIN = 4,
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int DW   = 32,
  localparam int CBASE = 8 + 2 * NWIN,
  localparam int RAW   = $clog2(CBASE + NWIN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  pc,
  input  logic           pc_valid,
  input  logic           cache_hit,
  input  logic           cache_miss,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data
);
  localparam logic [CW-1:0] CMAX = '1;

  logic            run;
  logic [NWIN-1:0] en;
  logic [NWIN-1:0] match;
  logic [AW-1:0]   lo  [NWIN];
  logic [AW-1:0]   hi  [NWIN];
  logic [CW-1:0]   cnt [NWIN];
  logic [CW-1:0]   hit_cnt, miss_cnt;

  wire clr  = wr_en && (wr_addr == RAW'(1));
  wire live = run && pc_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      en  <= '0;
    end else if (wr_en && wr_addr == RAW'(0)) begin
      run <= wr_data[0];
      en  <= wr_data[NWIN:1];
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign match[i] = en[i] && (pc >= lo[i]) && (pc <= hi[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        lo[i] <= '0;
        hi[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == RAW'(8 + 2 * i)) lo[i] <= wr_data[AW-1:0];
        if (wr_addr == RAW'(9 + 2 * i)) hi[i] <= wr_data[AW-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clr)                               cnt[i] <= '0;
      else if (live && match[i] && cnt[i] != CMAX)  cnt[i] <= cnt[i] + 1'b1;
    end

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt[i] == CMAX && !clr) |=> cnt[i] == CMAX);
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      !clr |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + 1'b1));
    // R4
    cnt_inverted_chk: assert property (@(posedge clk) disable iff (rst)
      (lo[i] > hi[i] && !clr) |=> $stable(cnt[i]));
    // R6
    cnt_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!live && !clr) |=> $stable(cnt[i]));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else if (run) begin
      if (cache_hit  && hit_cnt  != CMAX) hit_cnt  <= hit_cnt  + 1'b1;
      if (cache_miss && miss_cnt != CMAX) miss_cnt <= miss_cnt + 1'b1;
    end
  end

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hit_cnt == '0 && miss_cnt == '0));
  // R8
  hit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && run && cache_hit && hit_cnt != CMAX) |=> hit_cnt == $past(hit_cnt) + 1'b1);
  // R6
  event_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !run) |=> ($stable(hit_cnt) && $stable(miss_cnt)));

  always_comb begin
    rd_data = '0;
    if (rd_addr == RAW'(0)) rd_data = DW'({en, run});
    if (rd_addr == RAW'(2)) rd_data = DW'(hit_cnt);
    if (rd_addr == RAW'(3)) rd_data = DW'(miss_cnt);
    for (int i = 0; i < NWIN; i++) begin
      if (rd_addr == RAW'(8 + 2 * i))     rd_data = DW'(lo[i]);
      if (rd_addr == RAW'(9 + 2 * i))     rd_data = DW'(hi[i]);
      if (rd_addr == RAW'(CBASE + i))     rd_data = DW'(cnt[i]);
    end
  end
endmodule

// File: tb/pc_window_profiler_tb.sv
module pc_window_profiler_tb;
  localparam int NW = 4;
  localparam int CWT = 8;
  localparam int CB = 8 + 2 * NW;
  localparam logic [CWT-1:0] CMAXT = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pc = '0;
  logic pc_valid = 1'b0, cache_hit = 1'b0, cache_miss = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  pc_window_profiler #(.NWIN(NW), .AW(32), .CW(CWT), .DW(32)) u_dut (
    .clk(clk), .rst(rst), .pc(pc), .pc_valid(pc_valid), .cache_hit(cache_hit),
    .cache_miss(cache_miss), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  always #10 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;

  logic m_run;
  logic [NW-1:0] m_en;
  logic [31:0] m_lo [NW];
  logic [31:0] m_hi [NW];
  logic [CWT-1:0] m_cnt [NW];
  logic [CWT-1:0] m_hit, m_miss;

  task automatic model_reset();
    m_run = 0; m_en = '0; m_hit = '0; m_miss = '0;
    for (int w = 0; w < NW; w++) begin m_lo[w] = '0; m_hi[w] = '0; m_cnt[w] = '0; end
  endtask

  task automatic model_step();
    if (wr_en && wr_addr == 5'd1) begin
      m_hit = '0; m_miss = '0;
      for (int w = 0; w < NW; w++) m_cnt[w] = '0;
    end else if (m_run) begin
      for (int w = 0; w < NW; w++)
        if (m_en[w] && pc_valid && m_lo[w] <= pc && pc <= m_hi[w] && m_cnt[w] != CMAXT)
          m_cnt[w] = m_cnt[w] + 1'b1;
      if (cache_hit && m_hit != CMAXT) m_hit = m_hit + 1'b1;
      if (cache_miss && m_miss != CMAXT) m_miss = m_miss + 1'b1;
    end
    if (wr_en) begin
      if (wr_addr == 5'd0) begin m_run = wr_data[0]; m_en = wr_data[NW:1]; end
      for (int w = 0; w < NW; w++) begin
        if (wr_addr == 5'(8 + 2 * w)) m_lo[w] = wr_data;
        if (wr_addr == 5'(9 + 2 * w)) m_hi[w] = wr_data;
      end
    end
  endtask

  task automatic check_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #1;
    vectors++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int w = 0; w < NW; w++) check_reg(5'(CB + w), 32'(m_cnt[w]), tag);
    check_reg(5'd2, 32'(m_hit), tag);
    check_reg(5'd3, 32'(m_miss), tag);
  endtask

  task automatic cyc(input logic [31:0] p, input logic v, input logic h, input logic m,
                     input logic we, input logic [4:0] wa, input logic [31:0] wd, input string tag);
    @(negedge clk);
    pc = p; pc_valid = v; cache_hit = h; cache_miss = m;
    wr_en = we; wr_addr = wa; wr_data = wd;
    model_step();
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(32'h0, 1'b0, 1'b0, 1'b0, 1'b1, a, d, "R11");
  endtask

  task automatic run_pc(input logic [31:0] p, input string tag);
    cyc(p, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd1234);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: everything reads zero after reset
    #1;
    for (int a = 0; a < CB + NW; a++) check_reg(5'(a), 32'h0, "R1");

    wr(5'd8,  32'h4000027C); wr(5'd9,  32'h400003EF);
    wr(5'd10, 32'h40000300); wr(5'd11, 32'h40000400);
    wr(5'd12, 32'h40000500); wr(5'd13, 32'h40000400);
    wr(5'd14, 32'h400005D8); wr(5'd15, 32'h4000061F);
    // R11: write to control, readback
    wr(5'd0, 32'h1F);
    check_reg(5'd0, 32'h1F, "R11");
    check_reg(5'd8, 32'h4000027C, "R11");
    check_reg(5'd13, 32'h40000400, "R11");

    // R2: bound edges
    run_pc(32'h4000027C, "R2");
    run_pc(32'h400003EF, "R2");
    run_pc(32'h4000027B, "R2");
    run_pc(32'h400003F0, "R2");
    run_pc(32'h400005D8, "R2");
    run_pc(32'h4000061F, "R2");
    // R5: overlap region of windows 0 and 1
    run_pc(32'h40000350, "R5");
    run_pc(32'h40000350, "R5");
    // R4: inverted window 2 (0x40000500 > 0x40000400)
    run_pc(32'h40000450, "R4");
    run_pc(32'h40000500, "R4");
    // R6: pc_valid low
    cyc(32'h40000300, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 0, "R6");
    // R6: run off, nothing counts
    wr(5'd0, 32'h1E);
    cyc(32'h40000300, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 0, "R6");
    // R7: window 0 disabled
    wr(5'd0, 32'h1D);
    run_pc(32'h40000300, "R7");
    run_pc(32'h4000027C, "R7");
    wr(5'd0, 32'h1F);
    // R8: hit and miss events
    cyc(32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 0, "R8");
    cyc(32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 0, "R8");
    cyc(32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 0, "R8");
    // R10: clear with all increments pending
    cyc(32'h40000350, 1'b1, 1'b1, 1'b1, 1'b1, 5'd1, 0, "R10");
    // R9: saturation in window 3 and the hit counter
    for (int k = 0; k < 300; k++) cyc(32'h40000600, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 0, "R9");
    // R10 again after saturation
    cyc(32'h40000600, 1'b1, 1'b1, 1'b1, 1'b1, 5'd1, 0, "R10");

    // R3/R5/R6: random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] p;
      logic we;
      logic [4:0] wa;
      logic [31:0] wd;
      p  = 32'h40000200 + ($urandom % 32'h500);
      we = ($urandom % 60) == 0;
      wa = ($urandom % 2) ? 5'd1 : 5'd0;
      wd = {27'h0, 4'($urandom), 1'b1};
      if (($urandom % 8) == 0) wd[0] = 1'b0;
      cyc(p, 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom), we, wa, wd, "R3");
    end
    finish_run();
  end
endmodule